// File: doc/BRIEF.md
# Floppy Controller Drive Control Register

A byte-wide control register for a floppy disk controller, reached over a simple host I/O bus with an address, write data, read data and separate read and write strobes. One port address is decoded; writes land at any time and reads return the stored byte unchanged. The stored byte drives the drive-select lines, the spindle motor lines, a level-held software reset to the controller core, and the gating of the DMA and interrupt paths.

The low two bits form a binary drive number that pulls exactly one of four active-low select lines low. Each of the top four bits turns on one active-low motor line. Bit 2 is an active-low run bit. While it is 0 the core is held in reset, but the register keeps every other bit. Bit 3 enables the DMA request, DMA acknowledge, terminal count and interrupt paths. It only has this effect in AT mode. In PS/2 mode those paths stay live whatever the bit holds. The pad tri-states, the core and the other configuration registers are outside the block. It only exports their enables.

Top module: `fdc_ctl_reg`

## Requirements
- R1: After hardware reset (synchronous, `rst_n` low at a clock edge) the stored byte is 0x00. As a result `drv_sel_n` is 4'b1110, `motor_n` is 4'b1111 and `core_rst_n` is 0. In AT mode all four path enables are 0.
- R2: A write with `io_wr` high and `io_addr` equal to `PORT_ADDR` (default 0x03F2) stores `io_wdata` at that clock edge. A read of that address returns the stored byte exactly.
- R3: A write to any other address changes neither the stored byte nor any output.
- R4: `drv_sel_n[n]` is low exactly when bits [1:0] equal n, so only one line is low at a time. It updates at the same edge as the write.
- R5: `motor_n[i]` is the inverse of bit 4+i and updates at the same edge as the write.
- R6: `core_rst_n` equals bit 2. Writing 0 asserts the core reset, and it stays asserted until a 1 is written. The other seven bits are kept while the reset is held.
- R7: A write with bit 2 clear, followed on the very next cycle by a write with bit 2 set, holds `core_rst_n` low for exactly one clock.
- R8: With `ps2_mode` = 0 (AT mode), `drq_oe`, `irq_oe`, `dack_en` and `tc_en` all equal bit 3.
- R9: With `ps2_mode` = 1, all four enables are 1 regardless of bit 3, including while `rst_n` is low. A hardware reset still clears bit 3.
- R10: Writing 0x1C, 0x2D, 0x4E or 0x8F selects drive 0, 1, 2 or 3 respectively. Only that drive's motor is on, the DMA paths are enabled and the core reset is released.
- R11: `io_rdata` is 0x00 whenever there is no read of `PORT_ADDR` in the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| io_addr | input | ADDR_W (16) | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, zero unless the port is read |
| ps2_mode | input | 1 | 1 = PS/2 behaviour, 0 = AT behaviour |
| drv_sel_n | output | 4 | Active-low drive-select lines |
| motor_n | output | 4 | Active-low motor lines |
| core_rst_n | output | 1 | Active-low software reset to the controller core |
| drq_oe | output | 1 | Output enable for the DMA request pad |
| irq_oe | output | 1 | Output enable for the interrupt pad |
| dack_en | output | 1 | Enable for the DMA acknowledge input |
| tc_en | output | 1 | Enable for the terminal count input |

## Verification
The assertions assume the host never raises `io_rd` and `io_wr` in the same cycle, and that address and data are steady for the whole cycle in which a strobe is high. They also assume `ps2_mode` is not toggled on the cycle that follows an AT-mode write they judge. The stimulus applies each strobe for exactly one cycle, starting from the falling edge, and never overlaps a read with a write. The mode input changes only between sweeps, while the bus is idle. Every one of the 256 byte values is written and read back in each mode.

// File: rtl/fdc_ctl_pkg.sv
// Package: shared field layout and decode helpers for the drive control register.
// Assumes a fixed four-drive, byte-wide register whose bit positions are decoded
// by the neighbouring drive pins and DMA gating logic.
package fdc_ctl_pkg;

    localparam int NUM_DRIVES = 4;
    localparam int SEL_W      = $clog2(NUM_DRIVES);
    localparam int DATA_W     = 8;

    // Field order is behaviour: bit 7..4 motors, 3 DMA gate, 2 run, 1..0 drive number.
    typedef struct packed {
        logic [NUM_DRIVES-1:0] motor_on;
        logic                  dma_en;
        logic                  run_n;
        logic [SEL_W-1:0]      drive;
    } ctl_word_t;

    // Active-low one-cold select vector for a binary drive number.
    function automatic logic [NUM_DRIVES-1:0] sel_lines_n(input logic [SEL_W-1:0] code);
        logic [NUM_DRIVES-1:0] lines;
        for (int i = 0; i < NUM_DRIVES; i++) begin
            lines[i] = (code != SEL_W'(i));
        end
        return lines;
    endfunction

endpackage

// File: rtl/fdc_bus_port.sv
// Module: host bus port. Decodes the single register address into write and read
// hits and returns the stored byte on a read hit, zero otherwise.
// Assumes read and write strobes are never high together.
module fdc_bus_port #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_ADDR = 16'h03F2
) (
    input  logic [ADDR_W-1:0]             io_addr,
    input  logic                          io_wr,
    input  logic                          io_rd,
    input  logic [fdc_ctl_pkg::DATA_W-1:0] stored,
    output logic                          wr_hit,
    output logic [fdc_ctl_pkg::DATA_W-1:0] io_rdata
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

    logic addr_match;

    // Compare the bus address against the register's port.
    always_comb begin
        addr_match = (io_addr == MATCH);
        wr_hit     = io_wr && addr_match;
    end

    // Drive read data only while the port is being read.
    always_comb begin
        io_rdata = (io_rd && addr_match) ? stored : '0;
    end

endmodule

// File: rtl/fdc_ctl_store.sv
// Module: register storage. Holds the control byte and exposes both the current
// value and the value that will be loaded at the next edge, so output flops can
// load in step with the register. Synchronous active-low reset clears the byte.
module fdc_ctl_store (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_hit,
    input  logic [fdc_ctl_pkg::DATA_W-1:0] wdata,
    output fdc_ctl_pkg::ctl_word_t         ctl_q,
    output fdc_ctl_pkg::ctl_word_t         ctl_d
);
    import fdc_ctl_pkg::*;

    // Next value: reset wins, then a port write, else hold.
    always_comb begin
        if (!rst_n)      ctl_d = '0;
        else if (wr_hit) ctl_d = ctl_word_t'(wdata);
        else             ctl_d = ctl_q;
    end

    // Register the control byte.
    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/fdc_drive_pins.sv
// Module: drive interface pins. One select flop and one motor flop per drive,
// both active-low, loaded from the register's next value so that the pins move
// at the same edge as the register. Assumes the next value is already reset-forced.
module fdc_drive_pins (
    input  logic                                clk,
    input  logic                                rst_n,
    input  fdc_ctl_pkg::ctl_word_t              ctl_d,
    output logic [fdc_ctl_pkg::NUM_DRIVES-1:0]  drv_sel_n,
    output logic [fdc_ctl_pkg::NUM_DRIVES-1:0]  motor_n
);
    import fdc_ctl_pkg::*;

    logic [NUM_DRIVES-1:0] sel_next_n;

    // Decode the binary drive number into one-cold select lines.
    always_comb begin
        sel_next_n = sel_lines_n(ctl_d.drive);
    end

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
        // Select line for this drive; drive 0 is chosen by the cleared register.
        always_ff @(posedge clk) begin
            if (!rst_n) drv_sel_n[g] <= (g != 0);
            else        drv_sel_n[g] <= sel_next_n[g];
        end

        // Motor line for this drive, off after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) motor_n[g] <= 1'b1;
            else        motor_n[g] <= ~ctl_d.motor_on[g];
        end
    end

endmodule

// File: rtl/fdc_dma_gate.sv
// Module: DMA and interrupt path gating. In AT mode the four paths follow the
// register's DMA enable bit; in PS/2 mode they are held enabled, reset included.
// Assumes the mode input is quasi-static.
module fdc_dma_gate (
    input  logic ps2_mode,
    input  logic dma_en,
    output logic drq_oe,
    output logic irq_oe,
    output logic dack_en,
    output logic tc_en
);
    logic [3:0] path_on;

    for (genvar p = 0; p < 4; p++) begin : g_path
        // Each path is live in PS/2 mode or when the enable bit is set.
        assign path_on[p] = ps2_mode | dma_en;
    end

    // Map the gated paths onto their named enables.
    always_comb begin
        drq_oe  = path_on[0];
        irq_oe  = path_on[1];
        dack_en = path_on[2];
        tc_en   = path_on[3];
    end

endmodule

// File: rtl/fdc_ctl_reg.sv
// Module: top of the floppy drive control register. Joins the bus port, the
// storage, the drive pin flops and the DMA gating. The software reset output is
// the run bit itself, so holding it low never disturbs the other bits.
module fdc_ctl_reg #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_ADDR = 16'h03F2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    input  logic              ps2_mode,
    output logic [3:0]        drv_sel_n,
    output logic [3:0]        motor_n,
    output logic              core_rst_n,
    output logic              drq_oe,
    output logic              irq_oe,
    output logic              dack_en,
    output logic              tc_en
);
    import fdc_ctl_pkg::*;

    logic      wr_hit;
    ctl_word_t ctl_q;
    ctl_word_t ctl_d;

    fdc_bus_port #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_port (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .stored   (ctl_q),
        .wr_hit   (wr_hit),
        .io_rdata (io_rdata)
    );

    fdc_ctl_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (io_wdata),
        .ctl_q  (ctl_q),
        .ctl_d  (ctl_d)
    );

    fdc_drive_pins u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_d     (ctl_d),
        .drv_sel_n (drv_sel_n),
        .motor_n   (motor_n)
    );

    fdc_dma_gate u_gate (
        .ps2_mode (ps2_mode),
        .dma_en   (ctl_q.dma_en),
        .drq_oe   (drq_oe),
        .irq_oe   (irq_oe),
        .dack_en  (dack_en),
        .tc_en    (tc_en)
    );

    // Core reset follows the stored run bit directly.
    always_comb begin
        core_rst_n = ctl_q.run_n;
    end

endmodule

// File: rtl/fdc_ctl_reg_chk.sv
// Module: property checker for fdc_ctl_reg, observing only its ports.
// Assumes one strobe at a time and a mode input that is quiet around writes.
module fdc_ctl_reg_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PORT_ADDR = 16'h03F2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_wdata,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_rdata,
    input logic              ps2_mode,
    input logic [3:0]        drv_sel_n,
    input logic [3:0]        motor_n,
    input logic              core_rst_n,
    input logic              drq_oe,
    input logic              irq_oe,
    input logic              dack_en,
    input logic              tc_en
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(PORT_ADDR);

    // R4
    one_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~drv_sel_n) == 1);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == MATCH) |=>
            (motor_n == ~$past(io_wdata[7:4])) && (core_rst_n == $past(io_wdata[2])));

    // R3
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == MATCH) |=>
            $stable(drv_sel_n) && $stable(motor_n) && $stable(core_rst_n));

    // R8
    at_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps2_mode && io_wr && io_addr == MATCH) ##1 !ps2_mode |->
            (drq_oe == $past(io_wdata[3])) && (irq_oe == drq_oe) &&
            (dack_en == drq_oe) && (tc_en == drq_oe));

    // R9
    ps2_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps2_mode |-> (drq_oe && irq_oe && dack_en && tc_en));

    // R11
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == MATCH) |-> (io_rdata == 8'h00));

endmodule

bind fdc_ctl_reg fdc_ctl_reg_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_rdata   (io_rdata),
    .ps2_mode   (ps2_mode),
    .drv_sel_n  (drv_sel_n),
    .motor_n    (motor_n),
    .core_rst_n (core_rst_n),
    .drq_oe     (drq_oe),
    .irq_oe     (irq_oe),
    .dack_en    (dack_en),
    .tc_en      (tc_en)
);

// File: tb/sim_fdc_ctl_reg.sv
module sim_fdc_ctl_reg;
    localparam logic [15:0] PORT = 16'h03F2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        ps2_mode = 1'b0;
    logic [3:0]  drv_sel_n, motor_n;
    logic        core_rst_n, drq_oe, irq_oe, dack_en, tc_en;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    fdc_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .ps2_mode(ps2_mode),
        .drv_sel_n(drv_sel_n), .motor_n(motor_n), .core_rst_n(core_rst_n),
        .drq_oe(drq_oe), .irq_oe(irq_oe), .dack_en(dack_en), .tc_en(tc_en)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle write, entered and left on a falling edge.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // Combinational read sampled mid-cycle.
    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    function automatic logic [3:0] sel_exp(input logic [1:0] n);
        return ~(4'b0001 << n);
    endfunction

    function automatic logic [3:0] gate_exp(input logic ps2, input logic bit3);
        return (ps2 | bit3) ? 4'hF : 4'h0;
    endfunction

    initial begin
        #(4 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state in AT mode
        check("R1 sel", {12'h0, drv_sel_n}, 16'h000E);
        check("R1 motor", {12'h0, motor_n}, 16'h000F);
        check("R1 core_rst", {15'h0, core_rst_n}, 16'h0);
        check("R1 gates", {12'h0, drq_oe, irq_oe, dack_en, tc_en}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(PORT, rd);
        check("R1 readback", {8'h0, rd}, 16'h0000);
        // R11 idle read data
        check("R11 idle", {8'h0, io_rdata}, 16'h0);

        // Full sweep in both modes: R2 R4 R5 R6 R8 R9
        for (int m = 0; m < 2; m++) begin
            ps2_mode = m[0];
            @(negedge clk);
            for (int v = 0; v < 256; v++) begin
                bus_write(PORT, v[7:0]);
                check("R4 select", {12'h0, drv_sel_n}, {12'h0, sel_exp(v[1:0])});
                check("R5 motor", {12'h0, motor_n}, {12'h0, ~v[7:4]});
                check("R6 core_rst", {15'h0, core_rst_n}, {15'h0, v[2]});
                if (m == 0)
                    check("R8 at gates", {12'h0, drq_oe, irq_oe, dack_en, tc_en},
                          {12'h0, gate_exp(1'b0, v[3])});
                else
                    check("R9 ps2 gates", {12'h0, drq_oe, irq_oe, dack_en, tc_en}, 16'h000F);
                bus_read(PORT, rd);
                check("R2 readback", {8'h0, rd}, {8'h0, v[7:0]});
                bus_read(PORT ^ 16'h0001, rd);
                check("R11 other addr read", {8'h0, rd}, 16'h0);
            end
        end
        ps2_mode = 1'b0;
        @(negedge clk);

        // R3 writes to every single-bit-off address are ignored
        bus_write(PORT, 8'hA5);
        for (int b = 0; b < 16; b++) begin
            bus_write(PORT ^ (16'h1 << b), 8'h5A);
            check("R3 sel", {12'h0, drv_sel_n}, {12'h0, sel_exp(2'd1)});
            check("R3 motor", {12'h0, motor_n}, 16'h0005);
            bus_read(PORT, rd);
            check("R3 readback", {8'h0, rd}, 16'h00A5);
        end

        // R6 reset held keeps other bits; release restores run
        bus_write(PORT, 8'hB3);
        repeat (4) @(negedge clk);
        check("R6 held", {15'h0, core_rst_n}, 16'h0);
        bus_read(PORT, rd);
        check("R6 bits kept", {8'h0, rd}, 16'h00B3);
        bus_write(PORT, 8'hB7);
        check("R6 released", {15'h0, core_rst_n}, 16'h1);

        // R7 back-to-back pulse lasts one clock
        bus_write(PORT, 8'h1C);
        bus_write(PORT, 8'h18);
        check("R7 pulse low", {15'h0, core_rst_n}, 16'h0);
        bus_write(PORT, 8'h1C);
        check("R7 pulse end", {15'h0, core_rst_n}, 16'h1);

        // R10 drive activation values
        for (int n = 0; n < 4; n++) begin
            logic [7:0] val;
            val = 8'h0C | (8'h10 << n) | 8'(n);
            bus_write(PORT, val);
            check("R10 select", {12'h0, drv_sel_n}, {12'h0, sel_exp(n[1:0])});
            check("R10 motor", {12'h0, motor_n}, {12'h0, ~(4'b0001 << n)});
            check("R10 run+dma", {14'h0, core_rst_n, drq_oe}, 16'h0003);
        end

        // R9 PS/2 paths stay live in hardware reset; bit 3 still cleared
        bus_write(PORT, 8'h0C);
        ps2_mode = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 gates in reset", {12'h0, drq_oe, irq_oe, dack_en, tc_en}, 16'h000F);
        check("R1 core_rst again", {15'h0, core_rst_n}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(PORT, rd);
        check("R9 bit3 cleared", {8'h0, rd}, 16'h0000);
        ps2_mode = 1'b0;
        #1;
        check("R8 gates off after reset", {12'h0, drq_oe, irq_oe, dack_en, tc_en}, 16'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule